// File: doc/BRIEF.md
# Receive Byte-Sync Tracker

This block sits after an 8b/10b decoder and a comma detector on a receive lane and judges whether byte alignment is still held. It takes one decoded symbol per cycle, qualified by a valid strobe, together with two per-symbol flags. The first flag marks a bad symbol (code violation or disparity error). The second marks a detected comma. From these it keeps a three-state tracker: locked, relocking and lost. It reports that state on a 2-bit status port and raises a one-cycle realign request each time it starts relocking.

The symbol input is a stream with a valid qualifier and no ready. The tracker observes the stream and never applies back-pressure, so it accepts a symbol in every cycle that `sym_valid` is high. Cycles with `sym_valid` low carry no symbol and leave the tracker unchanged. A mode pin selects what the status port shows. With the mode high, the port shows the tracker state. With the mode low, it is a plain pass-through of the current bad-symbol flag. The tracker keeps running in both modes.

Top module: `rx_sync_tracker`

## Requirements
- R1: A synchronous active-high reset puts the tracker in the lost state. While reset is held and afterwards, with `fsm_mode` high, the status reads 2'b10 and `realign_req` is 0.
- R2: With `fsm_mode` high, `sync_status` is the registered state: 2'b00 locked, 2'b01 relocking, 2'b10 lost.
- R3: In the locked state, good symbols and idle cycles keep the state. A valid symbol with `sym_bad` high moves the tracker to lost in the next cycle.
- R4: Only a valid comma symbol whose `sym_bad` is low leaves the lost state, and it moves the tracker to relocking. A good non-comma symbol, or a comma flagged bad, keeps the tracker lost.
- R5: In relocking, the tracker returns to locked after GOOD_RUN (default 4) consecutive valid good symbols received after entry. The comma that caused the entry does not count.
- R6: A valid bad symbol during relocking moves the tracker to lost and discards the partial count. A later relock again needs a full GOOD_RUN symbols.
- R7: `realign_req` is high for exactly one cycle: the first cycle in which the state is relocking.
- R8: Cycles with `sym_valid` low change neither the state nor the good-symbol count, whatever `sym_bad` and `comma_seen` hold.
- R9: With `fsm_mode` low, `sync_status` is {1'b0, sym_valid & sym_bad} in the same cycle. The tracker still advances, so raising `fsm_mode` shows the state it reached.
- R10: A valid comma in the locked or relocking state counts as an ordinary good symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | A decoded symbol is present this cycle |
| sym_bad | input | 1 | The symbol has a code violation or disparity error |
| comma_seen | input | 1 | The symbol is a comma |
| fsm_mode | input | 1 | 1: status shows tracker state; 0: status passes the error flag through |
| sync_status | output | 2 | Tracker state or pass-through error flag |
| realign_req | output | 1 | One-cycle pulse when relocking begins |

## Verification
A vector run walks the tracker through every edge of its state graph. The run feeds bad symbols, bad commas and idle cycles with flags set in the lost state. These show that only a clean valid comma leaves it. A relock that is broken after one good symbol is followed by a full relock that needs four fresh good symbols, which tells a cleared count from a retained one. Commas and idle gaps inside a relock separate comma-as-data and valid-gating from plain counting. Directed tests cover the pass-through mode, the state kept while bypassed, and a reset during relocking.

// File: rtl/rx_sync_pkg.sv
package rx_sync_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED = 2'b00,
    ST_RELOCK = 2'b01,
    ST_LOST   = 2'b10
  } sync_state_e;
endpackage

// File: rtl/good_run_counter.sv
module good_run_counter #(
  parameter int GOOD_RUN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bump,
  output logic last
);
  localparam int CW = (GOOD_RUN > 1) ? $clog2(GOOD_RUN) : 1;
  localparam logic [CW-1:0] TOP = CW'(GOOD_RUN - 1);

  logic [CW-1:0] cnt;

  assign last = (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (bump && !last)
      cnt <= cnt + 1'b1;
  end

  // R5: the run count never passes the last step
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP);
endmodule

// File: rtl/sync_fsm.sv
module sync_fsm
  import rx_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sym_valid,
  input  logic        sym_bad,
  input  logic        comma_seen,
  input  logic        run_done,
  output sync_state_e state,
  output logic        realign,
  output logic        run_clr,
  output logic        run_bump
);
  sync_state_e nxt;
  logic        good, err, clean_comma;

  assign good        = sym_valid && !sym_bad;
  assign err         = sym_valid && sym_bad;
  assign clean_comma = good && comma_seen;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_LOCKED: if (err) nxt = ST_LOST;
      ST_LOST:   if (clean_comma) nxt = ST_RELOCK;
      ST_RELOCK: begin
        if (err) nxt = ST_LOST;
        else if (good && run_done) nxt = ST_LOCKED;
      end
      default: nxt = ST_LOST;
    endcase
  end

  assign run_clr  = (state != ST_RELOCK);
  assign run_bump = (state == ST_RELOCK) && good;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_LOST;
      realign <= 1'b0;
    end else begin
      state   <= nxt;
      realign <= (state == ST_LOST) && (nxt == ST_RELOCK);
    end
  end

  assert_err_drops_lock_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCKED && sym_valid && sym_bad) |=> state == ST_LOST);

  assert_lost_needs_comma_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOST && !(sym_valid && comma_seen && !sym_bad)) |=> state == ST_LOST);

  assert_realign_entry_R7: assert property (@(posedge clk) disable iff (rst)
    realign |-> (state == ST_RELOCK && $past(state) == ST_LOST));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |=> $stable(state));
endmodule

// File: rtl/status_select.sv
module status_select
  import rx_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        fsm_mode,
  input  sync_state_e state,
  input  logic        sym_valid,
  input  logic        sym_bad,
  output logic [1:0]  status
);
  assign status = fsm_mode ? 2'(state) : {1'b0, sym_valid & sym_bad};

  assert_lost_code_R2: assert property (@(posedge clk) disable iff (rst)
    (fsm_mode && state == ST_LOST) |-> status == 2'b10);

  assert_bypass_msb_R9: assert property (@(posedge clk) disable iff (rst)
    !fsm_mode |-> status[1] == 1'b0);
endmodule

// File: rtl/rx_sync_tracker.sv
module rx_sync_tracker
  import rx_sync_pkg::*;
#(
  parameter int GOOD_RUN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_valid,
  input  logic       sym_bad,
  input  logic       comma_seen,
  input  logic       fsm_mode,
  output logic [1:0] sync_status,
  output logic       realign_req
);
  sync_state_e state;
  logic        run_done, run_clr, run_bump;

  sync_fsm u_fsm (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_bad(sym_bad),
    .comma_seen(comma_seen), .run_done(run_done), .state(state),
    .realign(realign_req), .run_clr(run_clr), .run_bump(run_bump)
  );

  good_run_counter #(.GOOD_RUN(GOOD_RUN)) u_run (
    .clk(clk), .rst(rst), .clr(run_clr), .bump(run_bump), .last(run_done)
  );

  status_select u_sel (
    .clk(clk), .rst(rst), .fsm_mode(fsm_mode), .state(state),
    .sym_valid(sym_valid), .sym_bad(sym_bad), .status(sync_status)
  );
endmodule

// File: tb/tb_rx_sync_tracker.sv
module tb_rx_sync_tracker;
  logic clk = 1'b0;
  logic rst, sym_valid, sym_bad, comma_seen, fsm_mode;
  logic [1:0] sync_status;
  logic realign_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_sync_tracker #(.GOOD_RUN(4)) dut (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_bad(sym_bad),
    .comma_seen(comma_seen), .fsm_mode(fsm_mode),
    .sync_status(sync_status), .realign_req(realign_req)
  );

  // {valid, bad, comma, exp_status[1:0], exp_realign}, fsm_mode high
  localparam int NV = 20;
  localparam logic [5:0] TV [NV] = '{
    6'b100_10_0, // R4 good non-comma stays lost
    6'b111_10_0, // R4 bad comma stays lost
    6'b001_10_0, // R8 comma without valid ignored
    6'b101_01_1, // R4 R7 clean comma -> relock, pulse
    6'b100_01_0, // R5 count 1, R7 pulse gone
    6'b010_01_0, // R8 idle with bad flag ignored
    6'b100_01_0, // R5 count 2
    6'b101_01_0, // R10 comma counts, 3
    6'b100_00_0, // R5 count 4 -> locked
    6'b101_00_0, // R10 comma while locked
    6'b010_00_0, // R3 R8 idle keeps lock
    6'b110_10_0, // R3 bad -> lost
    6'b101_01_1, // R7 relock again
    6'b100_01_0, // R6 one good
    6'b110_10_0, // R6 bad -> lost
    6'b101_01_1, // R7 relock
    6'b100_01_0, // R6 fresh count 1
    6'b100_01_0, // R6 2
    6'b100_01_0, // R6 3 (stale count would lock here)
    6'b100_00_0  // R5 R6 4 -> locked
  };

  task automatic chk(input string req, input logic [1:0] st, input logic rr,
                     input logic [1:0] est, input logic err);
    checks++;
    if (st !== est || rr !== err) begin
      fails++;
      $display("FAIL %s: status=%b realign=%b expected status=%b realign=%b",
               req, st, rr, est, err);
    end
  endtask

  task automatic drive(input logic v, input logic b, input logic c);
    @(negedge clk);
    sym_valid = v; sym_bad = b; comma_seen = c;
  endtask

  task automatic settle;
    @(posedge clk); #2;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sym_valid = 0; sym_bad = 0; comma_seen = 0; fsm_mode = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset state", sync_status, realign_req, 2'b10, 1'b0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(TV[i][5], TV[i][4], TV[i][3]);
      settle();
      chk($sformatf("vector %0d", i), sync_status, realign_req, TV[i][2:1], TV[i][0]);
    end

    // R9 bypass: combinational flag, state still tracked (currently locked)
    @(negedge clk); fsm_mode = 1'b0; sym_valid = 1; sym_bad = 1; comma_seen = 0;
    #1 chk("R9 bypass bad", sync_status, realign_req, 2'b01, 1'b0);
    sym_valid = 0; #1 chk("R9 bypass invalid bad", sync_status, realign_req, 2'b00, 1'b0);
    sym_valid = 1; settle(); // bad valid symbol takes effect -> lost
    drive(1, 0, 0);
    #1 chk("R9 bypass good", sync_status, realign_req, 2'b00, 1'b0);
    settle();
    @(negedge clk); fsm_mode = 1'b1;
    #1 chk("R9 tracked while bypassed", sync_status, realign_req, 2'b10, 1'b0);

    // R1 reset during relock
    drive(1, 0, 1); settle();
    chk("R7 relock before reset", sync_status, realign_req, 2'b01, 1'b1);
    @(negedge clk); rst = 1'b1; sym_valid = 0; comma_seen = 0;
    settle();
    chk("R1 reset from relock", sync_status, realign_req, 2'b10, 1'b0);
    @(negedge clk); rst = 1'b0;
    drive(1, 0, 0); settle();
    chk("R1 R4 lost after reset", sync_status, realign_req, 2'b10, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule